// File: doc/BRIEF.md
# Oversampling Serial Receiver with Optional Ninth Data Bit

This block receives asynchronous serial characters. It samples the line 16 times per bit period and reads each character into an 11-bit shift register. A character has one start bit, eight or nine data bits and one stop bit. When the stop bit has been sampled, the block copies the data bits into a holding register that the host can only read. It then sets a full flag together with the status of that character: noise, framing error and parity error. The ninth data bit appears on its own output, apart from the low byte.

The line source is the input pin, or the local transmitter output when loop mode is on. The source can be inverted before the start bit is searched for. A programmable divider sets the sample rate. A host that reads too slowly sees an overrun flag, and the character held earlier is kept. An idle flag reports a quiet line after traffic.

Top module: `serial_rx9_top`

## Requirements
- R1: In 8-bit mode (`nineBit`=0) the block accepts a frame as a low start bit, 8 data bits with the least significant bit first, and a stop bit. `rxData` takes the 8 bits and `rxBit8` reads 0.
- R2: In 9-bit mode (`nineBit`=1) the block takes 9 data bits, least significant first. Bits 7..0 appear on `rxData` and bit 8 appears on `rxBit8`.
- R3: `full` rises one cycle after the stop bit is sampled. A one-cycle `rdStrobe` clears `full`, `overrun`, `noise`, `frameErr`, `parErr` and `idle` on the next clock edge.
- R4: If a frame completes while `full` is still set, `rxData`, `rxBit8` and the error flags keep their old values, and `overrun` is set.
- R5: Each bit takes the majority of samples 7, 8 and 9 of its 16 samples. If those three samples disagree in any bit of a frame, `noise` is set for that frame, and the decided data is unchanged.
- R6: With `parEn`=1, the last received data bit is the parity bit. It is stored as received in the most significant data position (bit 7 in 8-bit mode, `rxBit8` in 9-bit mode). `parOdd`=0 selects even parity and `parOdd`=1 selects odd parity. A mismatch sets `parErr`.
- R7: A stop bit decided as 0 sets `frameErr`. The receiver does not look for a new start bit until the line has been seen high.
- R8: With `loopEn`=1 the receiver listens to `loopIn`, and `rxPin` has no effect.
- R9: With `invPol`=1 the selected line is inverted before start-bit detection and sampling.
- R10: After a frame completes, `idle` sets once the line has stayed high for one whole frame length. That length is 10 bit periods in 8-bit mode and 11 bit periods in 9-bit mode. After a read clears it, `idle` does not set again until another frame completes.
- R11: A low pulse whose samples 7 to 9 are high is a false start. It is dropped, and no frame is loaded.
- R12: With `rxEn`=0 the receiver stays idle and loads no frames.
- R13: One bit period lasts 16 × `baudDiv` clock cycles. A `baudDiv` of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baudDiv | input | 13 | Clocks per sample tick |
| rxEn | input | 1 | Receiver enable |
| nineBit | input | 1 | 1 selects 9 data bits |
| parEn | input | 1 | Parity enable |
| parOdd | input | 1 | 1 selects odd parity |
| invPol | input | 1 | Invert the received line |
| loopEn | input | 1 | Take the line from loopIn |
| rxPin | input | 1 | Serial input pin |
| loopIn | input | 1 | Local transmitter output |
| rdStrobe | input | 1 | Host read of the holding register |
| rxData | output | 8 | Received data bits 7..0 |
| rxBit8 | output | 1 | Received data bit 8 |
| full | output | 1 | Holding register full |
| overrun | output | 1 | Frame lost while full |
| noise | output | 1 | Sample disagreement in the held frame |
| frameErr | output | 1 | Stop bit was low |
| parErr | output | 1 | Parity mismatch |
| idle | output | 1 | Line idle after traffic |

## Verification
A bad sample counter or bit counter moves the sampling point or the stop position. The fault shows up as shifted data bits or a false `frameErr` in the frame where it happens, one cycle after the stop sample. A wrong flag path, such as a missed overrun hold or a missed clear on read, shows on the flags in the cycle after the completing frame or after the read strobe. An idle counter with the wrong limit moves the rise of `idle` by whole bit periods. The bench therefore checks that `idle` is still low just after a frame and high after a full frame time.

// File: rtl/serial_rx9_pkg.sv
package serial_rx9_pkg;
  localparam int MAX_DATA = 9;
  localparam int SR_W     = MAX_DATA + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic startFrame;
    logic shiftEn;
    logic bitVal;
    logic bitNoisy;
    logic frameDone;
    logic lineIdle;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx9_baud.sv
module serial_rx9_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_comb begin
    tick = (baudDiv <= DIV_W'(1)) || (cnt >= baudDiv - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rstN)
    (tick && baudDiv > DIV_W'(1) && $stable(baudDiv)) |=> !tick);
endmodule

// File: rtl/serial_rx9_ctrl.sv
module serial_rx9_ctrl
  import serial_rx9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxEn,
  input  logic       nineBit,
  input  logic       invPol,
  input  logic       loopEn,
  input  logic       rxPin,
  input  logic       loopIn,
  output rxStrobe_t  stb
);
  localparam int SMP_W  = $clog2(OVS + 1);
  localparam int BIT_W  = $clog2(MAX_DATA);
  localparam int IDLE_W = $clog2(SR_W * OVS + 1);
  localparam int MID    = OVS / 2 + 1;

  rxState_t          state;
  logic [SMP_W-1:0]  smpCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [1:0]        syncQ;
  logic              line, prevHigh, s7, s8, maj, noisy, falseStart, atMid;
  logic [BIT_W-1:0]  lastBit;
  logic [IDLE_W-1:0] idleLimit;

  always_comb begin
    line       = syncQ[1] ^ invPol;
    maj        = (s7 & s8) | (s7 & line) | (s8 & line);
    noisy      = !((s7 == s8) && (s8 == line));
    lastBit    = nineBit ? BIT_W'(MAX_DATA - 1) : BIT_W'(MAX_DATA - 2);
    idleLimit  = nineBit ? IDLE_W'(SR_W * OVS) : IDLE_W'((SR_W - 1) * OVS);
    atMid      = tick && (smpCnt == SMP_W'(MID)) && (state != ST_IDLE);
    falseStart = atMid && (state == ST_START) && maj;
    stb.startFrame = rxEn && tick && (state == ST_IDLE) && prevHigh && !line;
    stb.shiftEn    = rxEn && atMid && !falseStart;
    stb.bitVal     = maj;
    stb.bitNoisy   = noisy;
    stb.frameDone  = rxEn && atMid && (state == ST_STOP);
    stb.lineIdle   = rxEn && tick && (state == ST_IDLE) && line &&
                     (idleCnt == idleLimit - IDLE_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else syncQ <= {syncQ[0], loopEn ? loopIn : rxPin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; smpCnt <= '0; bitCnt <= '0;
      s7 <= 1'b1; s8 <= 1'b1; prevHigh <= 1'b0;
    end else if (!rxEn) begin
      state <= ST_IDLE; smpCnt <= '0; bitCnt <= '0; prevHigh <= 1'b0;
    end else if (tick) begin
      prevHigh <= line;
      if (state == ST_IDLE) begin
        if (stb.startFrame) begin
          state  <= ST_START;
          smpCnt <= SMP_W'(1);
        end
      end else begin
        smpCnt <= (smpCnt == SMP_W'(OVS)) ? SMP_W'(1) : smpCnt + SMP_W'(1);
        if (smpCnt == SMP_W'(MID - 2)) s7 <= line;
        if (smpCnt == SMP_W'(MID - 1)) s8 <= line;
        if (falseStart || stb.frameDone) state <= ST_IDLE;
        else if (smpCnt == SMP_W'(OVS)) begin
          if (state == ST_START) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end else if (state == ST_DATA) begin
            if (bitCnt == lastBit) state <= ST_STOP;
            else bitCnt <= bitCnt + BIT_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (!rxEn || state != ST_IDLE || !line) idleCnt <= '0;
    else if (tick && idleCnt != idleLimit) idleCnt <= idleCnt + IDLE_W'(1);
  end

  assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> state == ST_IDLE);
  assert_start_not_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.startFrame, stb.frameDone}));
  assert_false_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && falseStart) |=> state == ST_IDLE);
endmodule

// File: rtl/serial_rx9_datapath.sv
module serial_rx9_datapath
  import serial_rx9_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  stb,
  input  logic       nineBit,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic       rdStrobe,
  output logic [7:0] rxData,
  output logic       rxBit8,
  output logic       full,
  output logic       overrun,
  output logic       noise,
  output logic       frameErr,
  output logic       parErr,
  output logic       idle
);
  logic [SR_W-1:0] shiftReg;
  logic            frameNoise, loadPulse, armed;
  logic [8:0]      dataBits;
  logic            startBit, stopBit, parBad;

  always_comb begin
    dataBits = nineBit ? shiftReg[SR_W-2:1] : {1'b0, shiftReg[SR_W-2:2]};
    startBit = nineBit ? shiftReg[0] : shiftReg[1];
    stopBit  = shiftReg[SR_W-1];
    parBad   = parEn && ((^dataBits) ^ parOdd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1; frameNoise <= 1'b0; loadPulse <= 1'b0;
    end else begin
      loadPulse <= stb.frameDone;
      if (stb.startFrame) frameNoise <= 1'b0;
      if (stb.shiftEn) begin
        shiftReg <= {stb.bitVal, shiftReg[SR_W-1:1]};
        if (stb.bitNoisy) frameNoise <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0; rxBit8 <= 1'b0; full <= 1'b0; overrun <= 1'b0;
      noise <= 1'b0; frameErr <= 1'b0; parErr <= 1'b0; idle <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (rdStrobe) begin
        full <= 1'b0; overrun <= 1'b0; noise <= 1'b0;
        frameErr <= 1'b0; parErr <= 1'b0; idle <= 1'b0;
      end
      if (loadPulse) begin
        armed <= 1'b1;
        if (full && !rdStrobe) overrun <= 1'b1;
        else begin
          rxData   <= dataBits[7:0];
          rxBit8   <= dataBits[8];
          full     <= 1'b1;
          noise    <= frameNoise;
          frameErr <= !stopBit || startBit;
          parErr   <= parBad;
        end
      end else if (stb.lineIdle && armed) begin
        idle  <= 1'b1;
        armed <= 1'b0;
      end
    end
  end

  assert_full_on_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> ##1 full);
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !loadPulse) |=> !full && !overrun && !noise && !frameErr && !parErr);
  assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loadPulse && full && !rdStrobe) |=> overrun && $stable(rxData) && $stable(rxBit8));
  assert_idle_after_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> $past(stb.lineIdle));
endmodule

// File: rtl/serial_rx9_top.sv
module serial_rx9_top
  import serial_rx9_pkg::*;
#(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             rxEn,
  input  logic             nineBit,
  input  logic             parEn,
  input  logic             parOdd,
  input  logic             invPol,
  input  logic             loopEn,
  input  logic             rxPin,
  input  logic             loopIn,
  input  logic             rdStrobe,
  output logic [7:0]       rxData,
  output logic             rxBit8,
  output logic             full,
  output logic             overrun,
  output logic             noise,
  output logic             frameErr,
  output logic             parErr,
  output logic             idle
);
  logic      tick;
  rxStrobe_t stb;

  serial_rx9_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(tick));

  serial_rx9_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEn(rxEn), .nineBit(nineBit),
    .invPol(invPol), .loopEn(loopEn), .rxPin(rxPin), .loopIn(loopIn), .stb(stb));

  serial_rx9_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nineBit(nineBit), .parEn(parEn),
    .parOdd(parOdd), .rdStrobe(rdStrobe), .rxData(rxData), .rxBit8(rxBit8),
    .full(full), .overrun(overrun), .noise(noise), .frameErr(frameErr),
    .parErr(parErr), .idle(idle));
endmodule

// File: tb/serial_rx9_top_tb.sv
module serial_rx9_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] baudDiv = 13'd1;
  logic        rxEn = 1'b1, nineBit = 1'b0, parEn = 1'b0, parOdd = 1'b0;
  logic        invPol = 1'b0, loopEn = 1'b0, rxPin = 1'b1, loopIn = 1'b1;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rxData;
  logic        rxBit8, full, overrun, noise, frameErr, parErr, idle;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  serial_rx9_top u_dut (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .rxEn(rxEn), .nineBit(nineBit),
    .parEn(parEn), .parOdd(parOdd), .invPol(invPol), .loopEn(loopEn),
    .rxPin(rxPin), .loopIn(loopIn), .rdStrobe(rdStrobe), .rxData(rxData),
    .rxBit8(rxBit8), .full(full), .overrun(overrun), .noise(noise),
    .frameErr(frameErr), .parErr(parErr), .idle(idle));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostRead();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  // frame bit 0 = start, then data LSB first, then stop
  task automatic sendFrame(input logic [8:0] data, input int nb, input logic stopV,
                           input int glitchIdx, input bit toLoop);
    logic [10:0] fr;
    int bitClks;
    fr = '0;
    for (int i = 0; i < nb; i++) fr[i+1] = data[i];
    fr[nb+1] = stopV;
    bitClks = 16 * ((baudDiv == 0) ? 1 : int'(baudDiv));
    for (int i = 0; i < nb + 2; i++) begin
      for (int c = 0; c < bitClks; c++) begin
        @(negedge clk);
        if (toLoop) loopIn = fr[i] ^ invPol;
        else rxPin = (fr[i] ^ (i == glitchIdx && c == 7)) ^ invPol;
      end
    end
    @(negedge clk);
    if (toLoop) loopIn = 1'b1 ^ invPol; else rxPin = 1'b1 ^ invPol;
    waitClk(2);
  endtask

  task automatic settle();
    waitClk(40);
    hostRead();
  endtask

  task automatic t_reset();
    check("R3 reset full", full, 0);
    check("R3 reset flags", {overrun, noise, frameErr, parErr, idle}, 0);
    check("R1 reset data", rxData, 0);
  endtask

  task automatic t_eight();
    settle();
    sendFrame(9'h0A5, 8, 1'b1, -1, 1'b0);
    check("R1 data", rxData, 8'hA5);
    check("R1 bit8", rxBit8, 0);
    check("R3 full set", full, 1);
    check("R3 no errors", {noise, frameErr, parErr, overrun}, 0);
    hostRead();
    check("R3 read clears full", full, 0);
    baudDiv = 13'd3;
    waitClk(10);
    sendFrame(9'h03C, 8, 1'b1, -1, 1'b0);
    check("R13 data at divisor 3", rxData, 8'h3C);
    check("R13 full at divisor 3", full, 1);
    baudDiv = 13'd1;
  endtask

  task automatic t_nine();
    settle();
    nineBit = 1'b1;
    sendFrame(9'h1A5, 9, 1'b1, -1, 1'b0);
    check("R2 low byte", rxData, 8'hA5);
    check("R2 ninth bit", rxBit8, 1);
    settle();
    sendFrame(9'h0FF, 9, 1'b1, -1, 1'b0);
    check("R2 ninth bit clear", {rxBit8, rxData}, 9'h0FF);
    nineBit = 1'b0;
  endtask

  task automatic t_overrun();
    settle();
    sendFrame(9'h011, 8, 1'b1, -1, 1'b0);
    sendFrame(9'h022, 8, 1'b1, -1, 1'b0);
    check("R4 data held", rxData, 8'h11);
    check("R4 overrun set", overrun, 1);
    check("R4 full kept", full, 1);
    hostRead();
    check("R3 read clears overrun", {full, overrun}, 0);
  endtask

  task automatic t_noise();
    settle();
    sendFrame(9'h0A5, 8, 1'b1, 4, 1'b0);
    check("R5 majority data", rxData, 8'hA5);
    check("R5 noise flag", noise, 1);
    hostRead();
    check("R3 read clears noise", noise, 0);
  endtask

  task automatic t_parity();
    settle();
    parEn = 1'b1; parOdd = 1'b0;
    sendFrame(9'h035, 8, 1'b1, -1, 1'b0);
    check("R6 even good", parErr, 0);
    check("R6 parity bit stored", rxData, 8'h35);
    settle();
    sendFrame(9'h0B5, 8, 1'b1, -1, 1'b0);
    check("R6 even bad", parErr, 1);
    settle();
    parOdd = 1'b1;
    sendFrame(9'h0B5, 8, 1'b1, -1, 1'b0);
    check("R6 odd good", parErr, 0);
    settle();
    nineBit = 1'b1;
    sendFrame(9'h101, 9, 1'b1, -1, 1'b0);
    check("R6 nine bit odd bad", {parErr, rxBit8}, 2'b11);
    parEn = 1'b0; parOdd = 1'b0; nineBit = 1'b0;
  endtask

  task automatic t_frame();
    settle();
    sendFrame(9'h05A, 8, 1'b0, -1, 1'b0);
    check("R7 framing error", frameErr, 1);
    check("R7 data", rxData, 8'h5A);
    settle();
    sendFrame(9'h066, 8, 1'b1, -1, 1'b0);
    check("R7 next frame clean", {frameErr, rxData}, 9'h066);
  endtask

  task automatic t_loop();
    settle();
    @(negedge clk) loopEn = 1'b1;
    waitClk(4);
    rxPin = 1'b0;
    sendFrame(9'h0C3, 8, 1'b1, -1, 1'b1);
    check("R8 loop data", rxData, 8'hC3);
    hostRead();
    waitClk(400);
    check("R8 pin ignored", full, 0);
    rxPin = 1'b1;
    waitClk(4);
    loopEn = 1'b0;
    waitClk(40);
  endtask

  task automatic t_invert();
    settle();
    @(negedge clk) begin invPol = 1'b1; rxPin = 1'b0; end
    waitClk(40);
    sendFrame(9'h096, 8, 1'b1, -1, 1'b0);
    check("R9 inverted data", rxData, 8'h96);
    check("R9 inverted flags", {frameErr, full}, 2'b01);
    settle();
    @(negedge clk) begin invPol = 1'b0; rxPin = 1'b1; end
    waitClk(40);
  endtask

  task automatic t_idle();
    settle();
    sendFrame(9'h01F, 8, 1'b1, -1, 1'b0);
    check("R10 idle not yet", idle, 0);
    waitClk(200);
    check("R10 idle set", idle, 1);
    hostRead();
    check("R10 idle cleared", idle, 0);
    waitClk(250);
    check("R10 idle stays clear", idle, 0);
  endtask

  task automatic t_false();
    settle();
    @(negedge clk) rxPin = 1'b0;
    waitClk(3);
    rxPin = 1'b1;
    waitClk(400);
    check("R11 false start ignored", full, 0);
  endtask

  task automatic t_disable();
    settle();
    @(negedge clk) rxEn = 1'b0;
    sendFrame(9'h077, 8, 1'b1, -1, 1'b0);
    waitClk(40);
    check("R12 disabled no load", full, 0);
    rxEn = 1'b1;
    waitClk(40);
    sendFrame(9'h078, 8, 1'b1, -1, 1'b0);
    check("R12 enabled again", {full, rxData}, 9'h178);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    t_reset();
    t_eight();
    t_nine();
    t_overrun();
    t_noise();
    t_parity();
    t_frame();
    t_loop();
    t_invert();
    t_idle();
    t_false();
    t_disable();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule